// File: doc/BRIEF.md
# Eight-bit timer/counter with power-of-two prescaler

This block is an eight-bit up-counter that software can load and read back, together with a small option byte that steers where its count pulses come from. Pulses come either from the system clock, divided by two, or from edges on an external input pin, which is synchronised first. Either source can pass through a prescaler that divides by a power of two from 2 to 256, or it can go straight to the counter.

When the counter wraps from FFh to 00h it raises a sticky overflow flag, which an interrupt controller elsewhere can pick up. Software clears the flag with a one-cycle clear strobe. Loading a new count also restarts the prescaler and the divide-by-two stage. From that point on, the first increment falls a known number of clocks later.

Top module: `evt_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising clock edge) the count reads 00h, the option byte reads 04h and ovf_flag is 0.
- R2: A write with wr_sel=0 loads wr_data into the count on that edge, and the count reads back on rd_data when rd_sel=0. A write with wr_sel=1 loads the option byte, which reads back with rd_sel=1. Bits 7:6 of the option byte always read 0.
- R3: With option bit 0 = 0 (internal source) and bit 2 = 1 (prescaler bypassed), the count advances by one every second clock. The first advance comes 2 clocks after a count write.
- R4: With bit 2 = 0 the prescaler is assigned, and rate code n in bits 5:3 gives a ratio of 2^(n+1). In internal mode the count then advances once every 2·2^(n+1) clocks after a count write.
- R5: While bit 2 = 1 the rate field has no effect on the count rate.
- R6: With bit 0 = 1 the count advances only on edges of ext_pin, after a two-flop synchroniser. Clocks with a steady pin leave the count unchanged.
- R7: Option bit 1 picks the counting edge of ext_pin: 0 counts rising edges only, 1 counts falling edges only.
- R8: A count write clears the prescaler and the divide-by-two stage, so any partial prescale progress made before the write is lost.
- R9: An advance from FFh sets ovf_flag and the count becomes 00h. ovf_flag stays set until ovf_clr is high at an edge. A set and a clear in the same cycle leave the flag set.
- R10: In external mode with the prescaler assigned, the count advances once per 2^(n+1) counted pin edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 option byte |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read select: 0 count, 1 option byte |
| rd_data | output | 8 | Read data (combinational) |
| ext_pin | input | 1 | Asynchronous external count input |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong divider or prescaler state shows up as a count that has moved too early or too late. In the fastest mode that error appears within two clocks of a count write. In the slowest mode it takes up to 512 clocks, so the long-ratio vectors wait several full periods before sampling. A broken synchroniser or edge selector shows up at the first pin transition, as a missing, doubled or wrong-polarity increment. A wrong overflow path shows up on the single advance out of FFh, or in the flag failing to hold over the cycles that follow.

// File: rtl/evt_timer_pkg.sv
// Package: shared constants and the decoded option record for evt_timer.
// Assumes an 8-bit option byte; bit positions below are the software contract.
package evt_timer_pkg;
    localparam int OPT_W        = 8;
    localparam int RATE_W       = 3;
    localparam int OPT_SRC_BIT  = 0;
    localparam int OPT_EDGE_BIT = 1;
    localparam int OPT_BYP_BIT  = 2;
    localparam int OPT_RATE_LSB = 3;
    localparam int OPT_USED     = OPT_RATE_LSB + RATE_W;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              bypass;
        logic              fall_edge;
        logic              ext_src;
    } opt_t;

    localparam opt_t OPT_RESET = '{rate: '0, bypass: 1'b1, fall_edge: 1'b0, ext_src: 1'b0};

    typedef enum logic {
        SEL_COUNT  = 1'b0,
        SEL_OPTION = 1'b1
    } reg_sel_e;

    // Unpack the used bits of an option byte into the record.
    function automatic opt_t decode_opt(input logic [OPT_W-1:0] b);
        opt_t o;
        o.ext_src   = b[OPT_SRC_BIT];
        o.fall_edge = b[OPT_EDGE_BIT];
        o.bypass    = b[OPT_BYP_BIT];
        o.rate      = b[OPT_RATE_LSB +: RATE_W];
        return o;
    endfunction

    // Repack the record into a byte; unused upper bits read zero.
    function automatic logic [OPT_W-1:0] encode_opt(input opt_t o);
        logic [OPT_W-1:0] b;
        b = '0;
        b[OPT_SRC_BIT]              = o.ext_src;
        b[OPT_EDGE_BIT]             = o.fall_edge;
        b[OPT_BYP_BIT]              = o.bypass;
        b[OPT_RATE_LSB +: RATE_W]   = o.rate;
        return b;
    endfunction
endpackage

// File: rtl/evt_timer_edge.sv
// Module: evt_timer_edge
// Brings the asynchronous pin into the clock domain through STAGES flops,
// then emits a one-cycle pulse on the selected edge (rising or falling).
// Assumes STAGES >= 2 and that the pin is stable for more than one clock.
module evt_timer_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic fall_sel,
    output logic edge_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              pin_s;

    // Synchroniser shift chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin_async};
    end

    assign pin_s = sync_q[STAGES-1];

    // Last synchronised level, kept for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_s;
    end

    // Edge decode, polarity chosen by fall_sel.
    always_comb begin
        if (fall_sel) edge_pulse = prev_q & ~pin_s;
        else          edge_pulse = pin_s & ~prev_q;
    end

    // R7: a counted edge cannot repeat on the next cycle unless the polarity changed
    edge_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> (!edge_pulse || (fall_sel != $past(fall_sel))));
endmodule

// File: rtl/evt_timer_presc.sv
// Module: evt_timer_presc
// Picks the pulse source (system clock halved, or external edges) and divides
// it by 2^(rate+1) unless bypassed. A restart clears both dividers.
// Assumes external pulses are never on two adjacent cycles.
module evt_timer_presc #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              ext_src,
    input  logic              ext_pulse,
    input  logic              bypass,
    input  logic [RATE_W-1:0] rate,
    output logic              adv
);
    localparam int PS_W = 1 << RATE_W;

    logic            half_q;
    logic [PS_W-1:0] pcnt_q;
    logic [PS_W-1:0] mask;
    logic            src_tick;
    logic            wrap;

    // Divide-by-two stage for the internal source.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) half_q <= 1'b0;
        else                   half_q <= ~half_q;
    end

    // Source select and terminal-count decode.
    always_comb begin
        src_tick = ext_src ? ext_pulse : half_q;
        mask     = {PS_W{1'b1}} >> (RATE_W'(PS_W - 1) - rate);
        wrap     = (pcnt_q & mask) == mask;
        adv      = bypass ? src_tick : (src_tick && wrap);
    end

    // Prescale counter, held at zero while bypassed.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || bypass) pcnt_q <= '0;
        else if (src_tick)               pcnt_q <= wrap ? '0 : pcnt_q + PS_W'(1);
    end

    // R3: the halved internal tick never appears on two adjacent cycles
    half_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_src && src_tick) |=> !half_q);

    // R4: a prescaled advance is followed by a cycle without one
    presc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !bypass) |=> !adv);
endmodule

// File: rtl/evt_timer_core.sv
// Module: evt_timer_core
// The loadable up-counter and its sticky wrap flag. A load wins over an
// advance in the same cycle; a wrap set wins over a clear.
module evt_timer_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             adv,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_flag
);
    logic wrap_now;

    assign wrap_now = adv && !load && (&cnt);

    // Count register: load, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (load) cnt <= load_val;
        else if (adv)  cnt <= cnt + CNT_W'(1);
    end

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_flag <= 1'b0;
        else if (wrap_now) ovf_flag <= 1'b1;
        else if (ovf_clr)  ovf_flag <= 1'b0;
    end

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1))));

    // R9
    flag_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ((cnt == '0) && ($past(cnt) == '1)));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

// File: rtl/evt_timer.sv
// Module: evt_timer (top)
// Holds the option byte, routes register writes and reads, and wires the
// synchroniser, prescaler and counter together. Reads are combinational.
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    input  logic             ext_pin,
    input  logic             ovf_clr,
    output logic             ovf_flag
);
    opt_t             opt_q;
    logic             cnt_load;
    logic             opt_load;
    logic             edge_pulse;
    logic             adv;
    logic [CNT_W-1:0] cnt;
    logic [OPT_W-1:0] opt_byte;

    // Write decode.
    always_comb begin
        cnt_load = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);
        opt_load = wr_en && (reg_sel_e'(wr_sel) == SEL_OPTION);
    end

    // Option register.
    always_ff @(posedge clk) begin
        if (!rst_n)        opt_q <= OPT_RESET;
        else if (opt_load) opt_q <= decode_opt(OPT_W'(wr_data));
    end

    evt_timer_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_async  (ext_pin),
        .fall_sel   (opt_q.fall_edge),
        .edge_pulse (edge_pulse)
    );

    evt_timer_presc #(.RATE_W(RATE_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (cnt_load),
        .ext_src   (opt_q.ext_src),
        .ext_pulse (edge_pulse),
        .bypass    (opt_q.bypass),
        .rate      (opt_q.rate),
        .adv       (adv)
    );

    evt_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (wr_data),
        .adv      (adv),
        .ovf_clr  (ovf_clr),
        .cnt      (cnt),
        .ovf_flag (ovf_flag)
    );

    // Read mux.
    always_comb begin
        opt_byte = encode_opt(opt_q);
        if (reg_sel_e'(rd_sel) == SEL_OPTION) rd_data = CNT_W'(opt_byte);
        else                                  rd_data = cnt;
    end

    // R6: in external mode nothing advances without a counted pin edge
    ext_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_q.ext_src && !edge_pulse) |-> !adv);
endmodule

// File: tb/evt_timer_bench.sv
// Bench for evt_timer: a vector table of timer-mode cases, then directed tests.
module evt_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       ext_pin = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evt_timer u_evt_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .ext_pin(ext_pin), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
    );

    typedef struct packed {
        logic [7:0]  opt;
        logic [7:0]  start;
        logic [15:0] cycles;
        logic [7:0]  exp_cnt;
        logic        exp_flag;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{8'h04, 8'h10, 16'd20,   8'h1A, 1'b0},  // R3
        '{8'h04, 8'h10, 16'd1,    8'h10, 1'b0},  // R3 not yet
        '{8'h00, 8'h00, 16'd40,   8'h0A, 1'b0},  // R4 ratio 2
        '{8'h08, 8'h05, 16'd64,   8'h0D, 1'b0},  // R4 ratio 4
        '{8'h08, 8'h00, 16'd7,    8'h00, 1'b0},  // R4 ratio 4 edge
        '{8'h10, 8'h20, 16'd47,   8'h22, 1'b0},  // R4 ratio 8
        '{8'h38, 8'h00, 16'd1100, 8'h02, 1'b0},  // R4 ratio 256
        '{8'h3C, 8'h00, 16'd10,   8'h05, 1'b0},  // R5 bypass ignores rate
        '{8'h04, 8'hF0, 16'd31,   8'hFF, 1'b0},  // R9 just before wrap
        '{8'h00, 8'hFE, 16'd8,    8'h00, 1'b1}   // R9 wrap
    };

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clr_flag();
        ovf_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ovf_clr = 1'b0;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic sel, input logic [7:0] exp);
        rd_sel = sel;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic pulse_pin(input int n);
        for (int i = 0; i < n; i++) begin
            ext_pin = 1'b1; tick(4);
            ext_pin = 1'b0; tick(4);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd_chk("R1 count", 1'b0, 8'h00);
        rd_chk("R1 option", 1'b1, 8'h04);
        chk("R1 flag", {7'd0, ovf_flag}, 8'h00);

        // R2 readback, unused bits zero
        wr(1'b1, 8'hFB);
        rd_chk("R2 option", 1'b1, 8'h3B);
        wr(1'b0, 8'hA5);
        wr(1'b1, 8'h04);
        rd_chk("R2 count", 1'b0, 8'hA5);

        // Table of timer-mode vectors
        for (int v = 0; v < NVEC; v++) begin
            clr_flag();
            wr(1'b1, VECS[v].opt);
            wr(1'b0, VECS[v].start);
            tick(int'(VECS[v].cycles));
            rd_chk($sformatf("R3/R4/R5/R9 vector %0d count", v), 1'b0, VECS[v].exp_cnt);
            chk($sformatf("R9 vector %0d flag", v), {7'd0, ovf_flag}, {7'd0, VECS[v].exp_flag});
        end

        // R9 flag holds, then clears
        tick(10);
        chk("R9 flag sticky", {7'd0, ovf_flag}, 8'h01);
        clr_flag();
        chk("R9 flag cleared", {7'd0, ovf_flag}, 8'h00);

        // R8 count write discards prescale progress (ratio 4, 8 clocks per step)
        wr(1'b1, 8'h08);
        wr(1'b0, 8'h00);
        tick(6);
        wr(1'b0, 8'h50);
        tick(6);
        rd_chk("R8 after restart", 1'b0, 8'h50);
        tick(2);
        rd_chk("R8 first step", 1'b0, 8'h51);

        // R6 external rising, bypass
        wr(1'b1, 8'h05);
        wr(1'b0, 8'h00);
        pulse_pin(3);
        rd_chk("R6 three rising edges", 1'b0, 8'h03);
        tick(30);
        rd_chk("R6 clocks ignored", 1'b0, 8'h03);

        // R7 rising counts on the rise only
        wr(1'b0, 8'h00);
        ext_pin = 1'b1; tick(6);
        rd_chk("R7 rising on rise", 1'b0, 8'h01);
        ext_pin = 1'b0; tick(6);
        rd_chk("R7 rising not on fall", 1'b0, 8'h01);

        // R7 falling counts on the fall only
        wr(1'b1, 8'h07);
        wr(1'b0, 8'h00);
        ext_pin = 1'b1; tick(6);
        rd_chk("R7 falling not on rise", 1'b0, 8'h00);
        ext_pin = 1'b0; tick(6);
        rd_chk("R7 falling on fall", 1'b0, 8'h01);

        // R10 external with prescaler ratio 2
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h00);
        pulse_pin(3);
        rd_chk("R10 three edges", 1'b0, 8'h01);
        pulse_pin(1);
        rd_chk("R10 four edges", 1'b0, 8'h02);

        // R1 reset mid-run
        wr(1'b1, 8'h00);
        tick(3);
        rst_n = 1'b0;
        tick(1);
        rst_n = 1'b1;
        rd_chk("R1 count after reset", 1'b0, 8'h00);
        rd_chk("R1 option after reset", 1'b1, 8'h04);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule